// File: doc/BRIEF.md
# Passcode-Locked Interrupt Register Front-End

This block is the 32-bit memory-mapped register face of a fuse controller. It handles a simple bus with separate write and read strobes, a word address and 32-bit data. It holds three things: a write-lock flag, a raw interrupt status word and an interrupt mask. From these it drives one level-sensitive interrupt line.

Writes to every register except the lock are dropped until software stores the unlock passcode into the lock register. The fuse datapath reports completions and failures through one-cycle event pulses, and each pulse sets its status bit. Software clears status bits by writing ones to them. The mask cannot be written directly. It changes only through an enable alias, which clears mask bits, and a disable alias, which sets them.

The word address map is: lock at word 0 (byte 0x00), status at word 12 (0x30), mask at word 13 (0x34), enable alias at word 14 (0x38) and disable alias at word 15 (0x3C). The live source bits are bits 14:0 and bit 31. Within them, bit 0 is program done, bit 1 is program error, bit 2 is read done, bit 3 is read error and bit 31 is a bus slave error.

Top module: `fuse_reg_front`

## Requirements
- R1: While rst_n is low at a clock edge, the block returns to its reset state: the lock reads 1, the status reads 0 and the mask reads 0x80007FFF.
- R2: A write to word 0 stores lock 0 if the data is exactly 0x0000DF0D, and lock 1 for any other value. The lock register is writable whether or not the block is locked.
- R3: While the lock reads 1, writes to any word other than 0 change neither the status nor the mask.
- R4: A high bit of evt_set sets the matching status bit at the next edge, but only for bits 14:0 and 31. Status bits 30:15 always read 0.
- R5: An unlocked write to word 12 clears each status bit whose data bit is 1 and leaves the other status bits unchanged.
- R6: If an event pulse and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R7: A write to word 13 never changes the mask.
- R8: An unlocked write to word 14 clears the mask bits that are 1 in the data. An unlocked write to word 15 sets them. Both words read 0.
- R9: irq is high exactly when some status bit is set whose mask bit is 0. It reflects the register values present after each clock edge.
- R10: A read of any word other than 0, 12 and 13 returns 0. rdata is 0 when rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe, data returned in the same cycle |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, 0 when rd_en is low |
| evt_set | input | 32 | Event pulses from the fuse datapath, one per status bit |
| irq | output | 1 | Level interrupt: pending status AND NOT mask |

## Verification
The hardest case to reach is a write-one-to-clear and a hardware event landing on the same status bit in the same cycle. This only matters once the block is unlocked and that bit is enabled, so that the collision is visible on irq. The stimulus first unlocks the block, enables a source and sets its bit. It then clears the bit while pulsing the same event, and checks both irq and a status read afterwards. The locked path is covered the same way: after relocking, the bench attempts a clear and a mask change and reads both registers back.

// File: rtl/fr_pkg.sv
// Shared constants and types for the fuse register front-end.
// Assumes 32-bit registers and word addressing.
package fr_pkg;
    localparam int          FR_DW        = 32;
    localparam logic [31:0] FR_SRC_VALID = 32'h8000_7FFF;
    localparam logic [31:0] FR_MASK_INIT = 32'h8000_7FFF;
    localparam logic [31:0] FR_PASSCODE  = 32'h0000_DF0D;
    localparam int          FR_W_LOCK    = 0;
    localparam int          FR_W_STAT    = 12;
    localparam int          FR_W_MASK    = 13;
    localparam int          FR_W_IEN     = 14;
    localparam int          FR_W_IDIS    = 15;

    // Write strobes after address decode and lock gating.
    typedef struct packed {
        logic lock_wr;
        logic stat_clr;
        logic ien_wr;
        logic idis_wr;
    } fr_wr_t;
endpackage

// File: rtl/fr_decode.sv
// Write decode: turns the bus write strobe into per-register strobes.
// Every strobe except the lock strobe is suppressed while locked.
// Assumes a single-word write per cycle.
module fr_decode
    import fr_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic          locked,
    output fr_wr_t        wr
);
    // Decode the address and gate by the lock flag.
    always_comb begin
        wr          = '0;
        wr.lock_wr  = wr_en && (addr == AW'(FR_W_LOCK));
        wr.stat_clr = wr_en && !locked && (addr == AW'(FR_W_STAT));
        wr.ien_wr   = wr_en && !locked && (addr == AW'(FR_W_IEN));
        wr.idis_wr  = wr_en && !locked && (addr == AW'(FR_W_IDIS));
    end
endmodule

// File: rtl/fr_lock_reg.sv
// Write-lock flag: resets to locked and unlocks only on the exact passcode.
module fr_lock_reg
    import fr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_wr,
    input  logic [FR_DW-1:0] wdata,
    output logic             lock_q
);
    // Store the comparison result of every lock write.
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= 1'b1;
        else if (lock_wr) lock_q <= (wdata != FR_PASSCODE);
    end
endmodule

// File: rtl/fr_status_reg.sv
// Raw interrupt status: event pulses set bits, software clears them by
// writing ones. An event wins over a clear in the same cycle.
// Bits outside VALID are tied to zero.
module fr_status_reg
    import fr_pkg::*;
#(
    parameter logic [FR_DW-1:0] VALID = FR_SRC_VALID
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [FR_DW-1:0] wdata,
    input  logic [FR_DW-1:0] evt,
    output logic [FR_DW-1:0] stat_q
);
    logic unused_rsvd;
    assign unused_rsvd = ^((wdata | evt) & ~VALID);

    for (genvar i = 0; i < FR_DW; i++) begin : g_bit
        if (VALID[i]) begin : g_live
            // Set on event, else clear on write-one.
            always_ff @(posedge clk) begin
                if (!rst_n)                   stat_q[i] <= 1'b0;
                else if (evt[i])              stat_q[i] <= 1'b1;
                else if (clr_en && wdata[i])  stat_q[i] <= 1'b0;
            end
        end else begin : g_rsvd
            assign stat_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/fr_mask_reg.sv
// Interrupt mask: reset value INIT. Changed only through the enable alias
// (clears bits) and the disable alias (sets bits). Bits outside VALID read 0.
module fr_mask_reg
    import fr_pkg::*;
#(
    parameter logic [FR_DW-1:0] VALID = FR_SRC_VALID,
    parameter logic [FR_DW-1:0] INIT  = FR_MASK_INIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_wr,
    input  logic             idis_wr,
    input  logic [FR_DW-1:0] wdata,
    output logic [FR_DW-1:0] mask_q
);
    logic unused_rsvd;
    assign unused_rsvd = ^(wdata & ~VALID);

    for (genvar i = 0; i < FR_DW; i++) begin : g_bit
        if (VALID[i]) begin : g_live
            // Clear on enable, set on disable.
            always_ff @(posedge clk) begin
                if (!rst_n)                    mask_q[i] <= INIT[i];
                else if (ien_wr && wdata[i])   mask_q[i] <= 1'b0;
                else if (idis_wr && wdata[i])  mask_q[i] <= 1'b1;
            end
        end else begin : g_rsvd
            assign mask_q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/fuse_reg_front.sv
// Passcode-locked register front-end with interrupt status and mask.
// Assumes full-word accesses; reads are combinational and qualified by rd_en.
module fuse_reg_front
    import fr_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [FR_DW-1:0] wdata,
    output logic [FR_DW-1:0] rdata,
    input  logic [FR_DW-1:0] evt_set,
    output logic             irq
);
    fr_wr_t           wr;
    logic             lock_q;
    logic [FR_DW-1:0] stat_q;
    logic [FR_DW-1:0] mask_q;

    fr_decode #(.AW(AW)) u_dec (
        .wr_en (wr_en),
        .addr  (addr),
        .locked(lock_q),
        .wr    (wr)
    );

    fr_lock_reg u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock_wr(wr.lock_wr),
        .wdata  (wdata),
        .lock_q (lock_q)
    );

    fr_status_reg #(.VALID(FR_SRC_VALID)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_en(wr.stat_clr),
        .wdata (wdata),
        .evt   (evt_set),
        .stat_q(stat_q)
    );

    fr_mask_reg #(.VALID(FR_SRC_VALID), .INIT(FR_MASK_INIT)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .ien_wr (wr.ien_wr),
        .idis_wr(wr.idis_wr),
        .wdata  (wdata),
        .mask_q (mask_q)
    );

    // Pending-and-enabled reduction for the interrupt line.
    assign irq = |(stat_q & ~mask_q);

    // Read mux; aliases and unmapped words return zero.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == AW'(FR_W_LOCK))      rdata = {{(FR_DW-1){1'b0}}, lock_q};
            else if (addr == AW'(FR_W_STAT)) rdata = stat_q;
            else if (addr == AW'(FR_W_MASK)) rdata = mask_q;
        end
    end
endmodule

// File: rtl/fr_checker.sv
// Temporal checks on the front-end, bound into every fuse_reg_front instance.
module fr_checker
    import fr_pkg::*;
#(
    parameter int AW = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [AW-1:0]    addr,
    input logic [FR_DW-1:0] wdata,
    input logic [FR_DW-1:0] evt_set,
    input logic             lock_q,
    input logic [FR_DW-1:0] stat_q,
    input logic [FR_DW-1:0] mask_q
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lock_q && stat_q == '0 && mask_q == FR_MASK_INIT)); // R1

    AST_LOCK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(FR_W_LOCK)) |=> (lock_q == ($past(wdata) != FR_PASSCODE))); // R2

    AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && wr_en && addr != AW'(FR_W_LOCK)) |=>
            ($stable(mask_q) && stat_q == ($past(stat_q) | ($past(evt_set) & FR_SRC_VALID)))); // R3

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_set[0] || evt_set[31]) |=>
            ((stat_q[0] || !$past(evt_set[0])) && (stat_q[31] || !$past(evt_set[31])))); // R6

    AST_MASK_NO_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(FR_W_MASK)) |=> $stable(mask_q)); // R7

    AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && wr_en && addr == AW'(FR_W_IEN)) |=>
            (mask_q == ($past(mask_q) & ~$past(wdata)))); // R8
endmodule

bind fuse_reg_front fr_checker #(.AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .evt_set(evt_set),
    .lock_q (lock_q),
    .stat_q (stat_q),
    .mask_q (mask_q)
);

// File: tb/sim_fuse_reg_front.sv
// Bench: behavioural reference model stepped every clock and compared at the
// ports (rdata when reading, irq every cycle).
module sim_fuse_reg_front;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] evt_set = '0;
    logic [31:0] rdata;
    logic        irq;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Reference state.
    bit          m_lock;
    logic [31:0] m_stat;
    logic [31:0] m_mask;
    localparam logic [31:0] LIVE = 32'h8000_7FFF;

    always #5 clk = ~clk;

    fuse_reg_front #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .evt_set(evt_set), .irq(irq)
    );

    function automatic logic [31:0] model_read(int a);
        case (a)
            0:       return {31'd0, m_lock};
            12:      return m_stat;
            13:      return m_mask;
            default: return 32'd0;
        endcase
    endfunction

    // One bus cycle: drive, compare outputs against the model, step the model.
    task automatic step(input string req, input bit wr, input bit rd,
                        input int a, input logic [31:0] d, input logic [31:0] e);
        bit          n_lock;
        logic [31:0] n_stat, n_mask, exp_rd;
        bit          exp_irq;
        @(negedge clk);
        wr_en = wr; rd_en = rd; addr = AW'(a); wdata = d; evt_set = e;
        #1;
        exp_irq = ((m_stat & ~m_mask) != 0);
        vectors++;
        if (irq !== exp_irq) begin
            errors++;
            $display("FAIL %s irq: got %0b expected %0b", req, irq, exp_irq);
        end
        if (rd) begin
            exp_rd = model_read(a);
            vectors++;
            if (rdata !== exp_rd) begin
                errors++;
                $display("FAIL %s read word %0d: got %08h expected %08h", req, a, rdata, exp_rd);
            end
        end
        n_lock = m_lock; n_stat = m_stat; n_mask = m_mask;
        if (wr) begin
            if (a == 0) n_lock = (d != 32'h0000_DF0D);
            else if (!m_lock) begin
                if (a == 12) n_stat = n_stat & ~(d & LIVE);
                if (a == 14) n_mask = n_mask & ~(d & LIVE);
                if (a == 15) n_mask = n_mask | (d & LIVE);
            end
        end
        n_stat = n_stat | (e & LIVE);
        @(posedge clk);
        m_lock = n_lock; m_stat = n_stat; m_mask = n_mask;
    endtask

    task automatic rd(input string req, input int a);
        step(req, 1'b0, 1'b1, a, 32'd0, 32'd0);
    endtask

    task automatic wr(input string req, input int a, input logic [31:0] d);
        step(req, 1'b1, 1'b0, a, d, 32'd0);
    endtask

    initial begin
        m_lock = 1'b1; m_stat = '0; m_mask = 32'h8000_7FFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd("R1", 0); rd("R1", 12); rd("R1", 13);

        // R3 locked: alias and clear writes dropped; events still land (R4)
        wr("R3", 14, 32'hFFFF_FFFF);
        wr("R3", 15, 32'h0000_0000);
        rd("R3", 13);
        step("R4", 1'b0, 1'b0, 0, 32'd0, 32'h0000_0001);
        wr("R3", 12, 32'h0000_0001);
        rd("R3", 12);

        // R2 passcode handling
        wr("R2", 0, 32'h0000_1234); rd("R2", 0);
        wr("R2", 0, 32'h0001_DF0D); rd("R2", 0);
        wr("R2", 0, 32'h0000_DF0D); rd("R2", 0);
        wr("R2", 0, 32'h0000_DF0D); rd("R2", 0);

        // R7 direct mask write ignored
        wr("R7", 13, 32'h0000_0000); rd("R7", 13);

        // R8 enable alias clears bit 0, aliases read zero; R9 irq rises
        wr("R8", 14, 32'h0000_0001);
        rd("R8", 13); rd("R8", 14); rd("R8", 15);
        rd("R9", 12);

        // R4 all events: reserved bits stay zero
        step("R4", 1'b0, 1'b0, 0, 32'd0, 32'hFFFF_FFFF);
        rd("R4", 12);

        // R5 write-one-to-clear of low nibble
        wr("R5", 12, 32'h0000_000F); rd("R5", 12);
        wr("R5", 12, 32'h0000_0000); rd("R5", 12);

        // R6 event and clear collide on bit 1 (enabled first)
        wr("R6", 14, 32'h0000_0002);
        step("R6", 1'b1, 1'b0, 12, 32'h0000_0002, 32'h0000_0002);
        rd("R6", 12);
        wr("R6", 12, 32'h0000_0002); rd("R6", 12);

        // R9 enable bit 31, then disable everything
        wr("R9", 14, 32'h8000_0000); rd("R9", 13);
        wr("R9", 15, 32'hFFFF_FFFF); rd("R9", 13);
        wr("R9", 14, 32'h0000_4000); rd("R9", 12);

        // R10 unmapped and alias reads
        rd("R10", 5); rd("R10", 1); rd("R10", 63); rd("R10", 14);
        step("R10", 1'b0, 1'b0, 12, 32'd0, 32'd0);

        // R3 after relock: clear and alias writes dropped
        wr("R3", 0, 32'h0000_0000);
        wr("R3", 12, 32'hFFFF_FFFF);
        wr("R3", 14, 32'hFFFF_FFFF);
        rd("R3", 12); rd("R3", 13); rd("R3", 0);

        // R1 reset mid-run restores defaults
        @(negedge clk); rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        @(posedge clk);
        m_lock = 1'b1; m_stat = '0; m_mask = 32'h8000_7FFF;
        @(negedge clk); rst_n = 1'b1;
        rd("R1", 0); rd("R1", 12); rd("R1", 13);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule